// File: doc/BRIEF.md
# Multiplexed Parallel Port Sequencer

This block carries 32-bit words between a pair of core-side word registers and an external 8-bit bus. The same eight wires carry both address and data. An access begins when the core writes a transmit word or asks for a receive word. From then on the sequencer runs the whole external access with no further help from the core. First it holds an address-latch phase of fixed length. During that phase it drives the start address on the shared bus and raises the latch strobe. Four byte-wide data phases follow, each with the read or write strobe low.

The length of a data phase comes from a 5-bit duration setting, with an optional extra bus-hold cycle. In that extra cycle the strobe is released while address and data stay stable. The total time of an access therefore depends only on those two settings. Software can use that fact to decide when the port may be turned off or pointed at a new address. The block raises a busy flag for the length of the access and a one-cycle done pulse after it.

Top module: `mux_port_seq`

## Requirements
- R1: The latch phase lasts exactly 3 clocks. During it, `ext_ale` is 1, `ext_ad_oe` is 1, `ext_ad_o` carries the low 8 bits of the start address, and `ext_addr` equals the full start address.
- R2: Each data phase lasts E + H clocks. E is the effective duration and H is the bus-hold bit. `busy` is therefore high for exactly 3 + 4·(E + H) consecutive clocks.
- R3: The effective duration E equals `cfg_dur` when `cfg_dur` is 3 or more. A setting of 0, 1 or 2 behaves exactly like 3.
- R4: A write (`tx_write`) places byte 0 (bits 7:0) of `tx_data` at the start address. Bytes 1, 2 and 3 go to the start address plus 1, plus 2 and plus 3. `ext_addr` steps by one after each data phase.
- R5: A read (`rx_read`) fetches bytes from the start address and the three following addresses. They are packed with the first byte in bits 7:0 and the last in bits 31:24. `rx_data` takes the new word in the same cycle that `done` rises.
- R6: In each data phase the strobe (`ext_wr_n` for writes, `ext_rd_n` for reads) is low for the first E clocks. It is high in the bus-hold clock. The two strobes are never low together, and neither is low outside a data phase.
- R7: `busy` rises together with the first latch clock and stays high through the last data clock. `done` is high for exactly the one clock that follows.
- R8: While `busy` is high, new requests are dropped, and clearing `cfg_enable` does not stop the word in progress.
- R9: While `cfg_enable` is 0 and the port is idle, requests are dropped and no access starts.
- R10: When `tx_write` and `rx_read` are both 1 in the same starting cycle, the write is performed, the read is dropped, and `rx_data` keeps its value.
- R11: During reset, `busy`, `done` and `ext_ale` are 0, both strobes are 1, `ext_ad_oe` is 0 and `rx_data` is 0.
- R12: Duration, hold, address and transmit word are sampled when the access starts. Changing them during the access affects neither its timing nor its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Port enable; gates the start of new accesses only |
| cfg_dur | input | 5 | Data phase duration in clocks (values below 3 act as 3) |
| cfg_hold | input | 1 | Adds one bus-hold clock to each data phase |
| cfg_addr | input | 16 | External start address |
| tx_data | input | 32 | Word to transmit |
| tx_write | input | 1 | Pulse: start a write access with `tx_data` |
| rx_read | input | 1 | Pulse: start a read access |
| rx_data | output | 32 | Last word assembled by a read access |
| busy | output | 1 | High during the external access |
| done | output | 1 | One-clock pulse after an access ends |
| ext_ale | output | 1 | Address latch strobe, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_addr | output | 16 | Current byte address of the access |
| ext_ad_o | output | 8 | Outgoing value on the multiplexed bus |
| ext_ad_oe | output | 1 | Drive enable for `ext_ad_o` |
| ext_ad_i | input | 8 | Incoming value on the multiplexed bus |

## Verification
Two events can fall in the same cycle. A write request and a read request can arrive together, and a new request can arrive while a word is still in progress. The bench raises both request lines in one idle cycle. It then checks that the memory holds the transmitted bytes and that `rx_data` is unchanged. Separately, partway through a transfer it pulses `tx_write`, clears the enable, and changes every configuration input. It then judges from the busy length, the strobe count, the memory contents and a quiet cycle after `done` that the running word finished on its original settings and that the late request left no trace.

// File: rtl/mps_pkg.sv
package mps_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_LATCH = 2'd1,
      SEQ_XFER  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/mps_phase_timer.sv
module mps_phase_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);

   assign last = run && (cnt == len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || last)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/mps_tx_lane.sv
module mps_tx_lane #(
   parameter int DATA_W    = 32,
   parameter int BUS_W     = 8,
   parameter bit LSB_FIRST = 1'b1,
   localparam int NBYTES   = DATA_W / BUS_W,
   localparam int SEL_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic [DATA_W-1:0] word,
   input  logic [SEL_W-1:0]  sel,
   output logic [BUS_W-1:0]  byte_o
);

   logic [SEL_W-1:0] lane;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign lane = sel;
      end else begin : g_msb
         assign lane = SEL_W'(NBYTES - 1) - sel;
      end
   endgenerate

   always_comb begin
      byte_o = word[int'(lane)*BUS_W +: BUS_W];
   end

endmodule

// File: rtl/mps_rx_pack.sv
module mps_rx_pack #(
   parameter int DATA_W    = 32,
   parameter int BUS_W     = 8,
   parameter bit LSB_FIRST = 1'b1,
   localparam int NBYTES   = DATA_W / BUS_W,
   localparam int SEL_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [SEL_W-1:0]  sel,
   input  logic [BUS_W-1:0]  byte_i,
   input  logic              finish,
   output logic [DATA_W-1:0] word_o
);

   logic [SEL_W-1:0]  lane;
   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] shift_nx;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign lane = sel;
      end else begin : g_msb
         assign lane = SEL_W'(NBYTES - 1) - sel;
      end
   endgenerate

   always_comb begin
      shift_nx = shift_q;
      if (capture)
         shift_nx[int'(lane)*BUS_W +: BUS_W] = byte_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         word_o  <= '0;
      end else begin
         shift_q <= shift_nx;
         if (finish)
            word_o <= shift_nx;
      end
   end

endmodule

// File: rtl/mux_port_seq.sv
module mux_port_seq
   import mps_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BUS_W     = 8,
   parameter int ADDR_W    = 16,
   parameter int DUR_W     = 5,
   parameter int ALE_CYC   = 3,
   parameter int MIN_DUR   = 3,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [DUR_W-1:0]  cfg_dur,
   input  logic              cfg_hold,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_write,
   input  logic              rx_read,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              done,
   output logic              ext_ale,
   output logic              ext_rd_n,
   output logic              ext_wr_n,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [BUS_W-1:0]  ext_ad_o,
   output logic              ext_ad_oe,
   input  logic [BUS_W-1:0]  ext_ad_i
);

   localparam int NBYTES = DATA_W / BUS_W;
   localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam int CNT_W  = DUR_W + 1;

   initial begin : p_param_chk
      assert (DATA_W % BUS_W == 0)
         else $fatal(1, "word width must be a multiple of bus width");
      assert (ADDR_W >= BUS_W)
         else $fatal(1, "address narrower than bus");
      assert (ALE_CYC >= 1 && ALE_CYC < (1 << CNT_W))
         else $fatal(1, "latch length out of counter range");
      assert (MIN_DUR >= 1 && MIN_DUR < (1 << DUR_W))
         else $fatal(1, "minimum duration out of field range");
   end

   seq_state_t        state_q;
   logic              dir_rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] tx_q;
   logic [CNT_W-1:0]  base_q;
   logic [CNT_W-1:0]  len_q;
   logic [SEL_W-1:0]  byte_q;
   logic              done_q;

   logic              start;
   logic [DUR_W-1:0]  eff_dur;
   logic [CNT_W-1:0]  phase_len;
   logic [CNT_W-1:0]  ph_cnt;
   logic              ph_last;
   logic              byte_last;
   logic              finish;
   logic              strobe;
   logic              capture;
   logic [BUS_W-1:0]  tx_byte;

   assign start     = (state_q == SEQ_IDLE) && cfg_enable && (tx_write || rx_read);
   assign eff_dur   = (cfg_dur < DUR_W'(MIN_DUR)) ? DUR_W'(MIN_DUR) : cfg_dur;
   assign phase_len = (state_q == SEQ_LATCH) ? CNT_W'(ALE_CYC) : len_q;
   assign byte_last = (byte_q == SEL_W'(NBYTES - 1));
   assign finish    = (state_q == SEQ_XFER) && ph_last && byte_last;
   assign strobe    = (state_q == SEQ_XFER) && (ph_cnt < base_q);
   assign capture   = strobe && dir_rd_q && (ph_cnt == base_q - CNT_W'(1));

   mps_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q != SEQ_IDLE),
      .len   (phase_len),
      .cnt   (ph_cnt),
      .last  (ph_last)
   );

   mps_tx_lane #(
      .DATA_W    (DATA_W),
      .BUS_W     (BUS_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_tx_lane (
      .word   (tx_q),
      .sel    (byte_q),
      .byte_o (tx_byte)
   );

   mps_rx_pack #(
      .DATA_W    (DATA_W),
      .BUS_W     (BUS_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_rx_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .sel     (byte_q),
      .byte_i  (ext_ad_i),
      .finish  (finish && dir_rd_q),
      .word_o  (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         dir_rd_q <= 1'b0;
         addr_q   <= '0;
         tx_q     <= '0;
         base_q   <= '0;
         len_q    <= '0;
         byte_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= finish;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q  <= SEQ_LATCH;
                  dir_rd_q <= !tx_write;
                  addr_q   <= cfg_addr;
                  tx_q     <= tx_data;
                  base_q   <= CNT_W'(eff_dur);
                  len_q    <= CNT_W'(eff_dur) + CNT_W'(cfg_hold);
                  byte_q   <= '0;
               end
            end
            SEQ_LATCH: begin
               if (ph_last)
                  state_q <= SEQ_XFER;
            end
            SEQ_XFER: begin
               if (ph_last) begin
                  addr_q <= addr_q + ADDR_W'(1);
                  if (byte_last)
                     state_q <= SEQ_IDLE;
                  else
                     byte_q <= byte_q + SEL_W'(1);
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SEQ_IDLE);
   assign done      = done_q;
   assign ext_ale   = (state_q == SEQ_LATCH);
   assign ext_rd_n  = !(strobe && dir_rd_q);
   assign ext_wr_n  = !(strobe && !dir_rd_q);
   assign ext_addr  = addr_q;
   assign ext_ad_oe = (state_q == SEQ_LATCH) || ((state_q == SEQ_XFER) && !dir_rd_q);

   always_comb begin
      if (state_q == SEQ_LATCH)
         ext_ad_o = addr_q[BUS_W-1:0];
      else if ((state_q == SEQ_XFER) && !dir_rd_q)
         ext_ad_o = tx_byte;
      else
         ext_ad_o = '0;
   end

endmodule

// File: rtl/mps_checker.sv
module mps_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic ext_ale,
   input logic ext_rd_n,
   input logic ext_wr_n,
   input logic ext_ad_oe
);

   // R1: latch strobe never lasts beyond three clocks
   assert_ale_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_ale && $past(ext_ale) && $past(ext_ale, 2)) |=> !ext_ale);

   // R1: bus driven whenever the latch strobe is high
   assert_ale_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ale |-> ext_ad_oe);

   // R6: strobes mutually exclusive
   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd_n || ext_wr_n));

   // R6: strobes only inside a data phase
   assert_strobe_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n || !ext_wr_n) |-> (busy && !ext_ale));

   // R7: access opens with the latch phase
   assert_busy_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ext_ale);

   // R7: done is a single clock right after busy
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8: a running access ends only through done
   assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind mux_port_seq mps_checker u_mps_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .ext_ale   (ext_ale),
   .ext_rd_n  (ext_rd_n),
   .ext_wr_n  (ext_wr_n),
   .ext_ad_oe (ext_ad_oe)
);

// File: tb/mux_port_seq_test.sv
`timescale 1ns/1ps
module mux_port_seq_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_enable;
   logic [4:0]  cfg_dur;
   logic        cfg_hold;
   logic [15:0] cfg_addr;
   logic [31:0] tx_data;
   logic        tx_write;
   logic        rx_read;
   logic [31:0] rx_data;
   logic        busy, done, ext_ale, ext_rd_n, ext_wr_n, ext_ad_oe;
   logic [15:0] ext_addr;
   logic [7:0]  ext_ad_o;
   logic [7:0]  ext_ad_i;
   logic [7:0]  mem [0:255];

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mux_port_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dur(cfg_dur),
      .cfg_hold(cfg_hold), .cfg_addr(cfg_addr), .tx_data(tx_data),
      .tx_write(tx_write), .rx_read(rx_read), .rx_data(rx_data), .busy(busy),
      .done(done), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
      .ext_addr(ext_addr), .ext_ad_o(ext_ad_o), .ext_ad_oe(ext_ad_oe),
      .ext_ad_i(ext_ad_i)
   );

   // behavioural byte memory
   assign ext_ad_i = !ext_rd_n ? mem[ext_addr[7:0]] : 8'h00;
   always @(posedge clk) if (!ext_wr_n) mem[ext_addr[7:0]] <= ext_ad_o;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int eff(input int d);
      return (d < 3) ? 3 : d;
   endfunction

   function automatic int total(input int d, input bit h);
      return 3 + 4 * (eff(d) + int'(h));
   endfunction

   task automatic access(input bit rd, input logic [15:0] a, input logic [4:0] d,
                         input bit h, input logic [31:0] w, input bit poke,
                         input bit both);
      logic [31:0] exp_rd, prev_rx;
      int cyc, ales, strobes, wrong;
      bit ad_ok;
      string tl;
      for (int i = 0; i < 4; i++) exp_rd[8*i +: 8] = mem[8'(a + 16'(i))];
      prev_rx = rx_data;
      @(negedge clk);
      cfg_enable = 1'b1; cfg_dur = d; cfg_hold = h; cfg_addr = a; tx_data = w;
      tx_write = !rd || both; rx_read = rd || both;
      @(negedge clk);
      tx_write = 1'b0; rx_read = 1'b0;
      cyc = 0; ales = 0; strobes = 0; wrong = 0; ad_ok = 1'b1;
      while (busy && cyc < 400) begin
         if (ext_ale) begin
            ales++;
            if (ext_ad_o !== a[7:0] || !ext_ad_oe || ext_addr !== a) ad_ok = 1'b0;
         end
         if ((rd && !both) ? !ext_rd_n : !ext_wr_n) strobes++;
         if ((rd && !both) ? !ext_wr_n : !ext_rd_n) wrong++;
         if (poke && cyc == 4) begin
            cfg_enable = 1'b0; cfg_dur = 5'd31; cfg_hold = !h;
            cfg_addr = a ^ 16'h00F0; tx_data = ~w; tx_write = 1'b1;
         end
         if (poke && cyc == 5) tx_write = 1'b0;
         @(negedge clk);
         cyc++;
      end
      tl = poke ? "R12" : ((d < 3) ? "R3" : "R2");
      chk(cyc == total(d, h), tl, "busy length", cyc, total(d, h));
      chk(ales == 3, "R1", "latch clocks", ales, 3);
      chk(ad_ok, "R1", "latch address", ext_addr, a);
      chk(strobes == 4 * eff(d), "R6", "strobe clocks", strobes, 4 * eff(d));
      chk(wrong == 0, "R6", "wrong strobe", wrong, 0);
      chk(done == 1'b1, "R7", "done after busy", done, 1);
      if (rd && !both) begin
         chk(rx_data == exp_rd, "R5", "read word", rx_data, exp_rd);
      end else begin
         for (int i = 0; i < 4; i++)
            chk(mem[8'(a + 16'(i))] == w[8*i +: 8], poke ? "R8" : "R4",
                "written byte", mem[8'(a + 16'(i))], w[8*i +: 8]);
         if (both) chk(rx_data == prev_rx, "R10", "rx kept", rx_data, prev_rx);
      end
      @(negedge clk);
      chk(done == 1'b0, "R7", "done one clock", done, 0);
      chk(busy == 1'b0, "R8", "no late start", busy, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      rst_n = 1'b0; cfg_enable = 1'b0; cfg_dur = '0; cfg_hold = 1'b0;
      cfg_addr = '0; tx_data = '0; tx_write = 1'b0; rx_read = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !ext_ale, "R11", "reset flags", {busy, done, ext_ale}, 0);
      chk(ext_rd_n && ext_wr_n && !ext_ad_oe, "R11", "reset strobes",
          {ext_rd_n, ext_wr_n, ext_ad_oe}, 3'b110);
      chk(rx_data == 32'h0, "R11", "reset rx", rx_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R11", "idle after reset", busy, 0);

      // directed corners
      access(1'b0, 16'h1240, 5'd3, 1'b0, 32'hA1B2C3D4, 1'b0, 1'b0);
      access(1'b1, 16'h1240, 5'd3, 1'b0, 32'h0, 1'b0, 1'b0);
      access(1'b0, 16'h00FE, 5'd0, 1'b1, 32'h11223344, 1'b0, 1'b0);
      access(1'b1, 16'h00FE, 5'd2, 1'b0, 32'h0, 1'b0, 1'b0);
      access(1'b1, 16'hBEEF, 5'd31, 1'b1, 32'h0, 1'b0, 1'b0);
      access(1'b0, 16'h3310, 5'd7, 1'b0, 32'h5566AA99, 1'b0, 1'b1);
      access(1'b0, 16'h4020, 5'd4, 1'b1, 32'hCAFE0123, 1'b1, 1'b0);

      // R9: requests while disabled are dropped
      @(negedge clk);
      cfg_enable = 1'b0; tx_write = 1'b1; rx_read = 1'b1;
      @(negedge clk);
      tx_write = 1'b0; rx_read = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(!busy && ext_wr_n && ext_rd_n, "R9", "disabled idle", busy, 0);
         @(negedge clk);
      end

      // random traffic
      for (int n = 0; n < 30; n++) begin
         access(1'($urandom), 16'($urandom), 5'($urandom), 1'($urandom),
                $urandom, 1'b0, 1'b0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule